// File: doc/BRIEF.md
# Flash Query-Mode Command Interpreter

This block is the command state machine of a flash memory model. It decides what a read returns. It watches qualified bus write cycles, each an address and a data word, and keeps one of three read modes. In normal-array mode a read passes the array word through. In identifier mode a read returns a manufacturer code or a device code. In query mode a read returns entries from a small fixed identification table. Program and erase algorithms, burst reads and any companion memory are handled elsewhere.

The query command is a write of 98h to address 55h. It is accepted from normal-array mode and from identifier mode. The block remembers which of the two modes was active when query mode was entered. The reset command, a write of F0h to any address, returns to that mode. Identifier mode is entered from normal-array mode with a three-write unlock sequence. A synchronous reset or a supply-lockout flag puts the machine back in normal-array mode and clears the remembered return mode. Reads are registered and answer one cycle after the request.

Top module: `cfiq_interp`

## Requirements
- R1: While `rst` is high, `mode` reads 2'b00 (normal array) and `rd_valid` is low, starting one cycle after the first clock edge with `rst` high. The mode encoding is 00 for normal array, 01 for identifier and 10 for query.
- R2: In normal-array mode, a write of 98h (low data byte) to address 055h sets `mode` to 10 at the clock edge that samples the write.
- R3: In identifier mode, a write of 98h to address 055h also sets `mode` to 10.
- R4: In query mode, a write whose low data byte is F0h, at any address, restores the mode that was active when query mode was entered: 00 or 01.
- R5: In normal-array mode, three consecutive writes move `mode` to 01: AAh at 555h, then 55h at 2AAh, then 90h at 555h. A wrong write anywhere in the sequence restarts it and leaves `mode` at 00.
- R6: In identifier mode, a write of F0h to any address returns `mode` to 00.
- R7: In query mode, reads return the following table: 10h gives 0051h, 11h gives 0052h, 12h gives 0059h, 13h gives 0002h, 15h gives 0040h, and 14h, 16h, 17h and 18h give 0000h.
- R8: In query mode, reads at addresses outside 10h..18h return 0000h.
- R9: A read request with `rd_en` high is answered one cycle later: `rd_valid` is high and `rd_data` is valid. Without a request, `rd_valid` is low in the next cycle.
- R10: In normal-array mode, `rd_data` is the `array_rdata` value sampled with the request. In identifier mode, address 000h returns the manufacturer code (default 0001h), address 001h returns the device code (default 227Eh), and any other address returns 0000h.
- R11: In query mode, every write whose low byte is not F0h is ignored, and `mode` stays at 10.
- R12: While `lockout` is high, `mode` is forced to 00 and writes are ignored. The remembered return mode is cleared, so a later F0h write leaves `mode` at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lockout | input | 1 | Supply-lockout flag. Forces normal-array mode and blocks writes |
| wr_en | input | 1 | Qualified write cycle strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 16 | Write data. The command is taken from the low byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| array_rdata | input | 16 | Array word returned in normal-array mode |
| mode | output | 2 | Current read mode: 00 array, 01 identifier, 10 query |
| rd_valid | output | 1 | Read answer valid, one cycle after `rd_en` |
| rd_data | output | 16 | Registered read data |

## Verification
A wrong mode register shows up on `mode` at the same edge that samples the offending write. It also shows up on `rd_data` in the answer to the next read, because a wrong mode selects the wrong source: array, identifiers or table. A corrupted return-mode memory is invisible until the F0h write that leaves query mode, and then it appears at once on `mode`. For this reason every query entry is followed by an exit from that same entry mode. A broken unlock stage shows up only when the third write lands: `mode` either fails to reach 01 or reaches it on a wrong sequence.

// File: rtl/cfiq_pkg.sv
package cfiq_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'b00,
    MODE_AUTOSEL = 2'b01,
    MODE_QUERY   = 2'b10
  } mode_e;

  // unlock progress in normal-array mode
  typedef enum logic [1:0] {
    UNLK_IDLE = 2'b00,
    UNLK_ONE  = 2'b01,
    UNLK_TWO  = 2'b10
  } unlk_e;

endpackage

// File: rtl/cfiq_cmd_fsm.sv
module cfiq_cmd_fsm
  import cfiq_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 16,
  parameter logic [7:0]  CMD_RESET  = 8'hF0,
  parameter logic [7:0]  CMD_QUERY  = 8'h98,
  parameter logic [7:0]  CMD_UNLK1  = 8'hAA,
  parameter logic [7:0]  CMD_UNLK2  = 8'h55,
  parameter logic [7:0]  CMD_IDENT  = 8'h90,
  parameter logic [11:0] ADR_QUERY  = 12'h055,
  parameter logic [11:0] ADR_UNLK_A = 12'h555,
  parameter logic [11:0] ADR_UNLK_B = 12'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lockout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_e             mode_q
);

  localparam int CMD_W = 8;

  mode_e ret_q, ret_d, mode_d;
  unlk_e unlk_q, unlk_d;

  logic [CMD_W-1:0] cmd;
  logic is_reset, is_query, is_u1, is_u2, is_id;

  assign cmd      = wr_data[CMD_W-1:0];
  assign is_reset = (cmd == CMD_RESET);
  assign is_query = (cmd == CMD_QUERY) && (wr_addr == ADDR_W'(ADR_QUERY));
  assign is_u1    = (cmd == CMD_UNLK1) && (wr_addr == ADDR_W'(ADR_UNLK_A));
  assign is_u2    = (cmd == CMD_UNLK2) && (wr_addr == ADDR_W'(ADR_UNLK_B));
  assign is_id    = (cmd == CMD_IDENT) && (wr_addr == ADDR_W'(ADR_UNLK_A));

  always_comb begin
    mode_d = mode_q;
    ret_d  = ret_q;
    unlk_d = unlk_q;
    if (wr_en) begin
      unique case (mode_q)
        MODE_ARRAY: begin
          if (is_reset) begin
            unlk_d = UNLK_IDLE;
          end else if (is_query) begin
            mode_d = MODE_QUERY;
            ret_d  = MODE_ARRAY;
            unlk_d = UNLK_IDLE;
          end else begin
            unique case (unlk_q)
              UNLK_IDLE: unlk_d = is_u1 ? UNLK_ONE : UNLK_IDLE;
              UNLK_ONE:  unlk_d = is_u2 ? UNLK_TWO : UNLK_IDLE;
              UNLK_TWO: begin
                unlk_d = UNLK_IDLE;
                if (is_id) mode_d = MODE_AUTOSEL;
              end
              default:   unlk_d = UNLK_IDLE;
            endcase
          end
        end
        MODE_AUTOSEL: begin
          if (is_reset) begin
            mode_d = MODE_ARRAY;
          end else if (is_query) begin
            mode_d = MODE_QUERY;
            ret_d  = MODE_AUTOSEL;
          end
        end
        MODE_QUERY: begin
          if (is_reset) begin
            mode_d = ret_q;
            ret_d  = MODE_ARRAY;
          end
        end
        default: mode_d = MODE_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || lockout) begin
      mode_q <= MODE_ARRAY;
      ret_q  <= MODE_ARRAY;
      unlk_q <= UNLK_IDLE;
    end else begin
      mode_q <= mode_d;
      ret_q  <= ret_d;
      unlk_q <= unlk_d;
    end
  end

endmodule

// File: rtl/cfiq_query_rom.sv
module cfiq_query_rom #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 16,
  parameter logic [11:0] TBL_BASE = 12'h010,
  parameter int          TBL_LEN  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);

  localparam int IDX_W = (TBL_LEN > 1) ? $clog2(TBL_LEN) : 1;

  function automatic logic [DATA_W-1:0] entry(input int idx);
    case (idx)
      0:       entry = DATA_W'(16'h0051);
      1:       entry = DATA_W'(16'h0052);
      2:       entry = DATA_W'(16'h0059);
      3:       entry = DATA_W'(16'h0002);
      5:       entry = DATA_W'(16'h0040);
      default: entry = '0;
    endcase
  endfunction

  logic [DATA_W-1:0] rom [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_rom
    assign rom[g] = entry(g);
  end

  logic [ADDR_W-1:0] offs;
  logic              hit;

  assign offs = addr - ADDR_W'(TBL_BASE);
  assign hit  = (addr >= ADDR_W'(TBL_BASE)) && (offs < ADDR_W'(TBL_LEN));
  assign data = hit ? rom[offs[IDX_W-1:0]] : '0;

endmodule

// File: rtl/cfiq_read_port.sv
module cfiq_read_port
  import cfiq_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 16,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h227E
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  input  logic [DATA_W-1:0] rom_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] id_data, sel_data;

  always_comb begin
    if (rd_addr == '0)                    id_data = DATA_W'(MFR_ID);
    else if (rd_addr == ADDR_W'(1))       id_data = DATA_W'(DEV_ID);
    else                                  id_data = '0;
  end

  always_comb begin
    unique case (mode)
      MODE_AUTOSEL: sel_data = id_data;
      MODE_QUERY:   sel_data = rom_data;
      default:      sel_data = array_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_data;
    end
  end

endmodule

// File: rtl/cfiq_interp.sv
module cfiq_interp
  import cfiq_pkg::*;
#(
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 16,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h227E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lockout,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [1:0]        mode,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  mode_e             mode_q;
  logic [DATA_W-1:0] rom_data;

  cfiq_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .lockout (lockout),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_q  (mode_q)
  );

  cfiq_query_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .addr (rd_addr),
    .data (rom_data)
  );

  cfiq_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode_q),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .array_rdata (array_rdata),
    .rom_data    (rom_data),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  assign mode = mode_q;

endmodule

// File: rtl/cfiq_interp_chk.sv
module cfiq_interp_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lockout,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        mode,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  logic qcmd, rcmd;
  assign qcmd = wr_en && (wr_addr == ADDR_W'(12'h055)) && (wr_data[7:0] == 8'h98);
  assign rcmd = wr_en && (wr_data[7:0] == 8'hF0);

  assert_lockout_array_R12: assert property (@(posedge clk) disable iff (rst)
    lockout |=> (mode == 2'b00));

  assert_enter_from_array_R2: assert property (@(posedge clk) disable iff (rst)
    (!lockout && mode == 2'b00 && qcmd) |=> (mode == 2'b10));

  assert_enter_from_ident_R3: assert property (@(posedge clk) disable iff (rst)
    (!lockout && mode == 2'b01 && qcmd) |=> (mode == 2'b10));

  assert_leave_query_R4: assert property (@(posedge clk) disable iff (rst)
    (!lockout && mode == 2'b10 && rcmd) |=> (mode != 2'b10));

  assert_query_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (!lockout && mode == 2'b10 && !rcmd) |=> (mode == 2'b10));

  assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_read_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_qry_first_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode == 2'b10 && rd_addr == ADDR_W'(12'h010)) |=> (rd_data == DATA_W'(16'h0051)));

  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

endmodule

bind cfiq_interp cfiq_interp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lockout  (lockout),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .mode     (mode),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/sim_cfiq_interp.sv
module sim_cfiq_interp;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 33;

  // {op(1: read, 0: write), addr[11:0], data[15:0], expected[15:0]}
  // write: expected is the mode after it; read: expected is rd_data
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 12'h010, 16'h0000, 16'hC010}, // R10 array passthrough
    {1'b0, 12'h055, 16'h0098, 16'h0002}, // R2
    {1'b1, 12'h010, 16'h0000, 16'h0051}, // R7
    {1'b1, 12'h011, 16'h0000, 16'h0052}, // R7
    {1'b1, 12'h012, 16'h0000, 16'h0059}, // R7
    {1'b1, 12'h013, 16'h0000, 16'h0002}, // R7
    {1'b1, 12'h014, 16'h0000, 16'h0000}, // R7
    {1'b1, 12'h015, 16'h0000, 16'h0040}, // R7
    {1'b1, 12'h016, 16'h0000, 16'h0000}, // R7
    {1'b1, 12'h018, 16'h0000, 16'h0000}, // R7
    {1'b1, 12'h019, 16'h0000, 16'h0000}, // R8
    {1'b1, 12'h00F, 16'h0000, 16'h0000}, // R8
    {1'b0, 12'h555, 16'h00AA, 16'h0002}, // R11
    {1'b0, 12'h055, 16'h0098, 16'h0002}, // R11
    {1'b0, 12'h123, 16'h00F0, 16'h0000}, // R4 back to array
    {1'b1, 12'h010, 16'h0000, 16'hC010}, // R10
    {1'b0, 12'h555, 16'h00AA, 16'h0000}, // R5
    {1'b0, 12'h2AA, 16'h0055, 16'h0000}, // R5
    {1'b0, 12'h555, 16'h0090, 16'h0001}, // R5
    {1'b1, 12'h000, 16'h0000, 16'h0001}, // R10
    {1'b1, 12'h001, 16'h0000, 16'h227E}, // R10
    {1'b1, 12'h002, 16'h0000, 16'h0000}, // R10
    {1'b0, 12'h055, 16'h0098, 16'h0002}, // R3
    {1'b1, 12'h011, 16'h0000, 16'h0052}, // R7
    {1'b0, 12'h000, 16'h00F0, 16'h0001}, // R4 back to ident
    {1'b1, 12'h001, 16'h0000, 16'h227E}, // R10
    {1'b0, 12'h7FF, 16'h00F0, 16'h0000}, // R6
    {1'b0, 12'h555, 16'h00AA, 16'h0000}, // R5 broken
    {1'b0, 12'h2AA, 16'h0056, 16'h0000}, // R5
    {1'b0, 12'h555, 16'h0090, 16'h0000}, // R5 no entry
    {1'b0, 12'h056, 16'h0098, 16'h0000}, // R2 wrong address
    {1'b0, 12'h055, 16'h0098, 16'h0002}, // R2
    {1'b0, 12'h055, 16'h12F0, 16'h0000}  // R4 low byte only
  };

  logic        clk = 1'b0;
  logic        rst, lockout, wr_en, rd_en;
  logic [11:0] wr_addr, rd_addr;
  logic [15:0] wr_data, array_rdata, rd_data;
  logic [1:0]  mode;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign array_rdata = {4'hC, rd_addr};

  cfiq_interp u0 (
    .clk(clk), .rst(rst), .lockout(lockout),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .array_rdata(array_rdata),
    .mode(mode), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; lockout = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 mode", {14'd0, mode}, 16'h0000);
    check("R1 rd_valid", {15'd0, rd_valid}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) begin
        do_read(VEC[i][43:32]);
        check("R9 valid", {15'd0, rd_valid}, 16'h0001);
        check($sformatf("R7/R8/R10 vec %0d", i), rd_data, VEC[i][15:0]);
      end else begin
        do_write(VEC[i][43:32], VEC[i][31:16]);
        check($sformatf("R2-R6/R11 vec %0d", i), {14'd0, mode}, VEC[i][15:0]);
      end
    end

    // R9: no request, no valid
    @(negedge clk);
    check("R9 idle", {15'd0, rd_valid}, 16'h0000);

    // R12: lockout from query entered via identifier mode clears return memory
    do_write(12'h555, 16'h00AA);
    do_write(12'h2AA, 16'h0055);
    do_write(12'h555, 16'h0090);
    check("R5 ident", {14'd0, mode}, 16'h0001);
    do_write(12'h055, 16'h0098);
    check("R3 query", {14'd0, mode}, 16'h0002);
    @(negedge clk); lockout = 1'b1;
    @(negedge clk);
    check("R12 forced", {14'd0, mode}, 16'h0000);
    do_write(12'h055, 16'h0098);
    check("R12 write ignored", {14'd0, mode}, 16'h0000);
    lockout = 1'b0;
    do_write(12'h000, 16'h00F0);
    check("R12 return cleared", {14'd0, mode}, 16'h0000);
    do_read(12'h012);
    check("R12 array read", rd_data, 16'hC012);

    // R1: reset in the middle of query mode
    do_write(12'h055, 16'h0098);
    check("R2 query", {14'd0, mode}, 16'h0002);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", {14'd0, mode}, 16'h0000);
    rst = 1'b0;
    do_read(12'h010);
    check("R1 array after reset", rd_data, 16'hC010);

    finish_run();
  end

endmodule